// File: doc/BRIEF.md
# IEC958 Subframe Formatter

This block turns a stream of interleaved linear PCM samples into 32-bit IEC958-style subframe words for an HDMI audio packet builder further down the pipe. Each 24-bit sample gets its own channel-status bit, zero user and validity flags, an even-parity bit and, once per status block, a block-start marker. The formatter counts channels within a frame and frames within the 192-frame status block. Every channel reads its own status stream: a 24-bit consumer template supplies the first three status bytes, and the channel-number nibble carries that channel's position.

Channel count, the status template and the mode are set up before a stream starts. A second mode takes words that software has already laid out as subframes, with flags on top and audio below, and moves the fields into the output layout. Both sides use valid/ready handshakes, and the result sits in a single output register. A restart input, or a change of mode, sends the counters back to the first channel of frame 0.

Top module: `iec_subframe_fmt`

## Requirements
- R1: In PCM mode the output word holds the sample in bits 23..0, validity (always 0) in bit 24, user (always 0) in bit 25, the channel-status bit in bit 26, parity in bit 27 and block start in bit 28. Bits 31..29 are always 0 in both modes.
- R2: In PCM mode bit 27 is chosen so that the XOR of output bits 27..0 is 0. Bit 28 does not enter the parity.
- R3: In PCM mode the channel index steps on each accepted word. After the last channel the index returns to 0 and the frame index steps, wrapping from 191 to 0. The status bit for frame n is bit (n mod 8) of status byte (n div 8).
- R4: For every channel, status byte 0 is cfg_status[7:0] and byte 1 is cfg_status[15:8]. Byte 2 has cfg_status[19:16] in its low nibble and the channel index plus one in bits 7:4 (frames 20..23). Bytes 3 to 23 are 0.
- R5: Bit 28 is set only on the word for channel 0 of frame 0.
- R6: The channel count is cfg_chan_cnt limited to the range 2 to 8. A value below 2 acts as 2 and a value above 8 acts as 8.
- R7: In pass-through mode the input carries P, C, U, V in bits 31..28, audio in bits 27..4 and a preamble code in bits 3..0. The output has P, C, U, V in bits 27..24, audio in bits 23..0, and bit 28 equal to input bit 3 (code 8 = block start). Counters do not advance in this mode.
- R8: While restart is high, in_ready is low. The next PCM word accepted after it is formatted as channel 0 of frame 0.
- R9: In the first cycle that cfg_passthru differs from the mode in use, in_ready is low and the counters reset. The first PCM word after a return to PCM mode is channel 0 of frame 0.
- R10: A word accepted on a clock edge appears on out_data with out_valid after that edge. out_data holds while out_valid is high and out_ready is low. in_ready is high when the output register is empty or being drained, unless R8 or R9 stalls it.
- R11: After reset, out_valid is 0, in_ready is 1 (PCM mode selected) and the counters are at channel 0 of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_chan_cnt | input | 4 | Channels per frame (limited to 2..8) |
| cfg_status | input | 24 | Consumer status template, status bytes 0..2 |
| cfg_passthru | input | 1 | 1 = repack preformatted subframes, 0 = PCM |
| restart | input | 1 | Return counters to channel 0, frame 0 |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | PCM sample (bits 23..0) or preformatted subframe |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Formatted subframe word |

## Verification
The assertions assume that upstream does not toggle cfg_passthru or cfg_chan_cnt while words are in flight. They also assume that every pass-through word carries a preamble nibble with at most one bit set. The stimulus changes configuration only while the input is idle and before a restart, and it draws pass-through preambles only from the codes 8, 4, 2 and 0. Backpressure on out_ready follows a repeating pattern, so that both stalls and held outputs occur while a status block is streaming.

// File: rtl/iec_fmt_pkg.sv
package iec_fmt_pkg;

    localparam int AUDIO_W      = 24;
    localparam int WORD_W       = 32;
    localparam int BLOCK_FRAMES = 192;
    localparam int MIN_CHANS    = 2;
    localparam int MAX_CHANS    = 8;
    localparam int TPL_BYTES    = 3;
    localparam int CHNUM_BYTE   = 2;
    localparam int TPL_W        = TPL_BYTES * 8;
    localparam int FRAME_W      = $clog2(BLOCK_FRAMES);
    localparam int CHAN_W       = $clog2(MAX_CHANS);
    localparam int CNT_W        = CHAN_W + 1;
    localparam int PASS_BLK_BIT = 3;
    localparam int PASS_AUD_LSB = 4;
    localparam int PASS_FLG_LSB = PASS_AUD_LSB + AUDIO_W;

    typedef enum logic {
        MODE_PCM  = 1'b0,
        MODE_PASS = 1'b1
    } fmt_mode_e;

    typedef struct packed {
        logic [WORD_W-AUDIO_W-6:0] rsv;
        logic                      blk;
        logic                      par;
        logic                      cs;
        logic                      usr;
        logic                      vld;
        logic [AUDIO_W-1:0]        audio;
    } subframe_t;

    function automatic logic [CHAN_W-1:0] last_chan(input logic [CNT_W-1:0] cnt);
        if (cnt < CNT_W'(MIN_CHANS))
            return CHAN_W'(MIN_CHANS - 1);
        else if (cnt > CNT_W'(MAX_CHANS))
            return CHAN_W'(MAX_CHANS - 1);
        else
            return CHAN_W'(cnt - 1'b1);
    endfunction

    function automatic logic even_fill(input subframe_t w);
        return ^{w.cs, w.usr, w.vld, w.audio};
    endfunction

endpackage

// File: rtl/iec_frame_seq.sv
module iec_frame_seq
    import iec_fmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               adv,
    input  logic [CHAN_W-1:0]  chan_last,
    output logic [FRAME_W-1:0] frame_idx,
    output logic [CHAN_W-1:0]  chan_idx,
    output logic               blk_first
);

    localparam logic [FRAME_W-1:0] FRAME_LAST = FRAME_W'(BLOCK_FRAMES - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            frame_idx <= '0;
            chan_idx  <= '0;
        end else if (adv) begin
            if (chan_idx >= chan_last) begin
                chan_idx  <= '0;
                frame_idx <= (frame_idx == FRAME_LAST) ? '0 : frame_idx + 1'b1;
            end else begin
                chan_idx <= chan_idx + 1'b1;
            end
        end
    end

    assign blk_first = (frame_idx == '0) && (chan_idx == '0);

endmodule

// File: rtl/iec_cs_lookup.sv
module iec_cs_lookup
    import iec_fmt_pkg::*;
(
    input  logic [FRAME_W-1:0] frame_idx,
    input  logic [CHAN_W-1:0]  chan_idx,
    input  logic [TPL_W-1:0]   tpl,
    output logic               cs_bit
);

    localparam int SEL_W = FRAME_W - 3;

    logic [7:0]       stat_byte [TPL_BYTES];
    logic [SEL_W-1:0] byte_sel;
    logic [2:0]       bit_sel;

    generate
        for (genvar b = 0; b < TPL_BYTES; b++) begin : g_byte
            if (b == CHNUM_BYTE) begin : g_chnum
                assign stat_byte[b] = {4'(chan_idx) + 4'd1, tpl[b*8 +: 4]};
            end else begin : g_plain
                assign stat_byte[b] = tpl[b*8 +: 8];
            end
        end
    endgenerate

    assign byte_sel = frame_idx[FRAME_W-1:3];
    assign bit_sel  = frame_idx[2:0];

    always_comb begin
        cs_bit = 1'b0;
        for (int b = 0; b < TPL_BYTES; b++) begin
            if (byte_sel == SEL_W'(b))
                cs_bit = stat_byte[b][bit_sel];
        end
    end

endmodule

// File: rtl/iec_word_pack.sv
module iec_word_pack
    import iec_fmt_pkg::*;
(
    input  fmt_mode_e          mode,
    input  logic [WORD_W-1:0]  raw,
    input  logic               cs_bit,
    input  logic               blk_first,
    output subframe_t          word
);

    always_comb begin
        word = '0;
        if (mode == MODE_PASS) begin
            word.audio = raw[PASS_AUD_LSB +: AUDIO_W];
            word.vld   = raw[PASS_FLG_LSB];
            word.usr   = raw[PASS_FLG_LSB + 1];
            word.cs    = raw[PASS_FLG_LSB + 2];
            word.par   = raw[PASS_FLG_LSB + 3];
            word.blk   = raw[PASS_BLK_BIT];
        end else begin
            word.audio = raw[AUDIO_W-1:0];
            word.vld   = 1'b0;
            word.usr   = 1'b0;
            word.cs    = cs_bit;
            word.blk   = blk_first;
            word.par   = even_fill(word);
        end
    end

endmodule

// File: rtl/iec_subframe_fmt.sv
module iec_subframe_fmt
    import iec_fmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   cfg_chan_cnt,
    input  logic [TPL_W-1:0]   cfg_status,
    input  logic               cfg_passthru,
    input  logic               restart,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_data
);

    fmt_mode_e          mode_q;
    fmt_mode_e          mode_req;
    logic               mode_chg;
    logic               stall;
    logic               accept;
    logic               adv;
    logic [CHAN_W-1:0]  chan_last;
    logic [FRAME_W-1:0] frame_idx;
    logic [CHAN_W-1:0]  chan_idx;
    logic               blk_first;
    logic               cs_bit;
    subframe_t          word_nxt;
    subframe_t          word_q;

    assign mode_req  = cfg_passthru ? MODE_PASS : MODE_PCM;
    assign mode_chg  = (mode_req != mode_q);
    assign stall     = restart || mode_chg;
    assign in_ready  = (!out_valid || out_ready) && !stall;
    assign accept    = in_valid && in_ready;
    assign adv       = accept && (mode_q == MODE_PCM);
    assign chan_last = last_chan(cfg_chan_cnt);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_PCM;
        else
            mode_q <= mode_req;
    end

    iec_frame_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .clr       (stall),
        .adv       (adv),
        .chan_last (chan_last),
        .frame_idx (frame_idx),
        .chan_idx  (chan_idx),
        .blk_first (blk_first)
    );

    iec_cs_lookup i_cs (
        .frame_idx (frame_idx),
        .chan_idx  (chan_idx),
        .tpl       (cfg_status),
        .cs_bit    (cs_bit)
    );

    iec_word_pack i_pack (
        .mode      (mode_q),
        .raw       (in_data),
        .cs_bit    (cs_bit),
        .blk_first (blk_first),
        .word      (word_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            word_q    <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            word_q    <= word_nxt;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign out_data = word_q;

endmodule

// File: rtl/iec_subframe_fmt_chk.sv
module iec_subframe_fmt_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_passthru,
    input logic        restart,
    input logic        in_valid,
    input logic        in_ready,
    input logic [31:0] in_data,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data
);

    logic pass_tag;

    always_ff @(posedge clk) begin
        if (rst)
            pass_tag <= 1'b0;
        else if (in_valid && in_ready)
            pass_tag <= cfg_passthru;
    end

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_data[31:29] == 3'b000); // R1

    AST_PCM_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !pass_tag) |-> out_data[25:24] == 2'b00); // R1

    AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !pass_tag) |-> (^out_data[27:0]) == 1'b0); // R2

    AST_RESTART_STALL: assert property (@(posedge clk) disable iff (rst)
        restart |-> !in_ready); // R8

    AST_PASS_REMAP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && cfg_passthru) |=>
            out_data[28:0] == {$past(in_data[3]), $past(in_data[31:4])}); // R7

    AST_PREAMBLE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && cfg_passthru) |-> $onehot0(in_data[3:0])); // R7

    AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid); // R10

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

endmodule

bind iec_subframe_fmt iec_subframe_fmt_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_passthru (cfg_passthru),
    .restart      (restart),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data)
);

// File: tb/test_iec_subframe_fmt.sv
module test_iec_subframe_fmt;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_chan_cnt = 4'd2;
    logic [23:0] cfg_status = '0;
    logic        cfg_passthru = 1'b0;
    logic        restart = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;

    always #2 clk = ~clk;

    iec_subframe_fmt i_iec_subframe_fmt (
        .clk          (clk),
        .rst          (rst),
        .cfg_chan_cnt (cfg_chan_cnt),
        .cfg_status   (cfg_status),
        .cfg_passthru (cfg_passthru),
        .restart      (restart),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_data     (out_data)
    );

    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    int          m_frame = 0;
    int          m_chan = 0;
    int          m_cnt = 2;
    bit          bp_en = 1'b0;
    int          mon_cyc = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    function automatic int clamp_cnt(input int c);
        if (c < 2) return 2;
        if (c > 8) return 8;
        return c;
    endfunction

    // Status bytes: 0,1 from template, 2 = {chan+1, template low nibble}, rest zero (R4)
    function automatic logic [31:0] exp_pcm(input logic [23:0] a, input int fr, input int ch,
                                            input logic [23:0] tpl);
        logic [7:0] sb;
        logic [3:0] num;
        logic       cs;
        logic       blk;
        logic       par;
        int         bi;
        bi  = fr / 8;
        num = 4'(ch + 1);
        sb  = 8'h00;
        if (bi == 0) sb = tpl[7:0];
        else if (bi == 1) sb = tpl[15:8];
        else if (bi == 2) sb = {num, tpl[19:16]};
        cs  = sb[fr % 8];
        blk = (fr == 0) && (ch == 0);
        par = ^{cs, a};
        return {3'b000, blk, par, cs, 2'b00, a};
    endfunction

    task automatic drive(input logic [31:0] d);
        bit ok;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        forever begin
            #1;
            ok = in_ready;
            @(posedge clk);
            if (ok) break;
            @(negedge clk);
        end
        #1 in_valid = 1'b0;
    endtask

    task automatic send_pcm(input logic [23:0] a, input string tag);
        exp_q.push_back(exp_pcm(a, m_frame, m_chan, cfg_status));
        tag_q.push_back(tag);
        if (m_chan >= m_cnt - 1) begin
            m_chan  = 0;
            m_frame = (m_frame == 191) ? 0 : m_frame + 1;
        end else begin
            m_chan++;
        end
        drive({8'h00, a});
    endtask

    task automatic send_pass(input logic [31:0] d, input string tag);
        exp_q.push_back({3'b000, d[3], d[31:28], d[27:4]});
        tag_q.push_back(tag);
        drive(d);
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        #1 check("R8 in_ready during restart", {31'd0, in_ready}, 32'd0);
        @(posedge clk);
        #1 restart = 1'b0;
        m_frame = 0;
        m_chan  = 0;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        cfg_passthru = m;
        #1 check("R9 in_ready on mode change", {31'd0, in_ready}, 32'd0);
        m_frame = 0;
        m_chan  = 0;
    endtask

    task automatic set_chans(input logic [3:0] c);
        @(negedge clk);
        cfg_chan_cnt = c;
        m_cnt = clamp_cnt(int'(c));
        do_restart();
    endtask

    // Monitor: choose out_ready, then score the word that moves at the next edge
    always @(negedge clk) begin
        logic  rdy;
        string tg;
        logic [31:0] ex;
        mon_cyc++;
        rdy = bp_en ? ((mon_cyc % 3) != 2) : 1'b1;
        out_ready = rdy;
        if (!rst && out_valid && rdy) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected output", out_data, 32'hxxxxxxxx);
            end else begin
                ex = exp_q.pop_front();
                tg = tag_q.pop_front();
                check(tg, out_data, ex);
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
        check("R11 in_ready after reset", {31'd0, in_ready}, 32'd1);

        // Stereo across two full status blocks, with backpressure
        cfg_status = 24'h5B_C3_06;
        bp_en = 1'b1;
        for (int i = 0; i < 2 * 192 * 2 + 6; i++)
            send_pcm(24'(i * 24'h03A5C7 + 24'h0F0), "R1 R2 R3 R5 R10 stereo");

        // Eight channels, channel-number field for each
        cfg_status = 24'hE7_0F_81;
        set_chans(4'd8);
        for (int i = 0; i < 8 * 30; i++)
            send_pcm(24'(i * 24'h0B1D3 ^ 24'hA5A5A5), "R4 R8 eight channels");

        // Count below range behaves as stereo
        bp_en = 1'b0;
        set_chans(4'd1);
        for (int i = 0; i < 2 * 192 + 4; i++)
            send_pcm(24'(i * 24'h1357), "R6 count below range");

        // Count above range behaves as eight
        set_chans(4'd13);
        for (int i = 0; i < 8 * 25; i++)
            send_pcm(24'(24'hFFFFFF - i * 24'h77), "R6 count above range");

        // Restart in the middle of a block
        bp_en = 1'b1;
        set_chans(4'd5);
        for (int i = 0; i < 17; i++)
            send_pcm(24'(i + 24'h800000), "R3 five channels");
        do_restart();
        for (int i = 0; i < 12; i++)
            send_pcm(24'(i * 24'h111111), "R8 R5 after restart");

        // Pass-through repacking
        set_mode(1'b1);
        for (int i = 0; i < 40; i++) begin
            logic [31:0] w;
            logic [3:0]  pre;
            pre = (i % 4 == 0) ? 4'h8 : (i % 4 == 1) ? 4'h4 : (i % 4 == 2) ? 4'h2 : 4'h0;
            w = 32'(i * 32'h9E3779B1);
            send_pass({w[31:4], pre}, "R7 pass-through");
        end

        // Back to PCM: counters start from channel 0, frame 0
        set_mode(1'b0);
        for (int i = 0; i < 10; i++)
            send_pcm(24'(i * 24'h2468AC), "R9 R5 back to PCM");

        for (int k = 0; k < 200 && exp_q.size() != 0; k++)
            @(negedge clk);
        repeat (5) @(negedge clk);
        check("R10 words left in scoreboard", 32'(exp_q.size()), 32'd0);
        report();
    end

endmodule